// File: doc/BRIEF.md
# Self-Timed EEPROM Byte Write Sequencer with Completion Poller

This block sits on the host side of a parallel, self-timed EEPROM. A requester hands it one address and one data byte. The block drives the chip-select, read-strobe and write-strobe sequence onto the memory pins. The setup, strobe-width and hold phases each last a parameterised number of clocks.

After the write strobe rises, the memory finishes the byte on its own. The block then watches for the end of that internal write. It can do this in one of two ways, chosen per request:

- **Data polling.** It reads back the written address repeatedly. While the write is still running, the most significant data bit comes back inverted. The write has finished when that bit equals the written bit 7.
- **Busy line.** It watches an open-drain ready/busy line, which several devices may share. The write has finished once that line has been seen low and then seen high again.

If neither sign of completion appears within a bounded number of clocks, the block reports a timeout instead. It reports either a one-cycle done pulse or a one-cycle timeout pulse, and then accepts the next request.

Top module: `eeprom_write_poller`

## Requirements
- R1: After reset, `mem_ce_n`, `mem_oe_n` and `mem_we_n` are all 1, `mem_dout_oe` is 0, `req_ready` is 1, and `done` and `timeout` are 0.
- R2: An accepted write first holds `mem_ce_n` low for SETUP_CYC clocks with `mem_we_n` high. It then drives `mem_we_n` low for exactly PULSE_CYC clocks, and then holds `mem_ce_n` low with `mem_we_n` high for HOLD_CYC clocks. `mem_addr` and `mem_dout` stay equal to the request's address and byte for the whole time `mem_ce_n` is low.
- R3: `mem_oe_n` is 1 whenever `mem_we_n` is 0. `mem_dout_oe` is 0 whenever `mem_oe_n` is 0.
- R4: In data-poll mode (`req_mode_busy`=0), each poll read holds `mem_ce_n`=0, `mem_oe_n`=0 and `mem_we_n`=1 for READ_CYC clocks at the written address. On the last of those clocks, `mem_poll_msb` (data bit 7) is compared with bit 7 of the written byte; equality completes the write.
- R5: In data-poll mode, successive poll reads, and the write and the first read, are separated by at least GAP_CYC clocks with all three strobes high.
- R6: In busy-line mode (`req_mode_busy`=1, `rdy_busy_n` low = busy), the write completes only after the synchronised `rdy_busy_n` has been seen 0 and then 1 following the write strobe. No poll read is performed in this mode.
- R7: If completion has not been seen after TIMEOUT_CYC clocks of polling, counted from the end of the hold phase, `timeout` pulses and `done` does not.
- R8: `done` and `timeout` are each high for one clock, never together, and the block is idle (`req_ready`=1) on the following clock.
- R9: A request is taken only while `req_ready` is 1. A `req_valid` raised during an operation causes no further write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request strobe, taken when req_ready is 1 |
| req_ready | output | 1 | Block is idle and will accept a request |
| req_addr | input | ADDR_W | Byte address |
| req_data | input | 8 | Byte to write |
| req_mode_busy | input | 1 | 0: data polling, 1: ready/busy line |
| mem_addr | output | ADDR_W | Address pins |
| mem_dout | output | 8 | Data to the memory |
| mem_dout_oe | output | 1 | Host drives the data bus |
| mem_poll_msb | input | 1 | Data bus bit 7 from the memory |
| mem_ce_n | output | 1 | Chip select, active low |
| mem_oe_n | output | 1 | Read strobe, active low |
| mem_we_n | output | 1 | Write strobe, active low |
| rdy_busy_n | input | 1 | Shared ready/busy line, low while busy |
| done | output | 1 | One-cycle pulse: write confirmed |
| timeout | output | 1 | One-cycle pulse: completion not seen in time |

## Verification
The bench builds the block with SETUP_CYC=2, PULSE_CYC=3, HOLD_CYC=2, READ_CYC=2, GAP_CYC=3 and TIMEOUT_CYC=200.

The short timeout lets a memory model that never finishes trigger the timeout within a few hundred cycles. The same small bound lets random busy times of up to 40 clocks cover many poll rounds in both modes.

Strobe lengths above one clock make the phase counters wrap. A zero busy time checks that completion is recognised on the very first read.

// File: rtl/ewp_pkg.sv
package ewp_pkg;
  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_SETUP      = 3'd1,
    ST_PULSE      = 3'd2,
    ST_HOLD       = 3'd3,
    ST_POLL_READ  = 3'd4,
    ST_POLL_CHECK = 3'd5,
    ST_DONE       = 3'd6,
    ST_TIMEOUT    = 3'd7
  } ewp_state_e;
endpackage

// File: rtl/ewp_sync2.sv
module ewp_sync2 (
  input  logic clk,
  input  logic rst_n,
  input  logic async_i,
  output logic sync_o
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b1;
      sync_q <= 1'b1;
    end else begin
      meta_q <= async_i;
      sync_q <= meta_q;
    end
  end

  assign sync_o = sync_q;
endmodule

// File: rtl/ewp_phase_counter.sv
module ewp_phase_counter #(
  parameter int CW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic [CW-1:0] len,
  output logic          last
);
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_d;

  assign last = (cnt_q == len - 1'b1);

  always_comb begin
    if (clear || last) cnt_d = '0;
    else               cnt_d = cnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  // R2: the phase count never runs past the programmed length
  a_r2_count_in_range: assert property (@(posedge clk) disable iff (!rst_n)
    (!clear && len != '0) |-> (cnt_q < len));
endmodule

// File: rtl/ewp_timeout_timer.sv
module ewp_timeout_timer #(
  parameter int LIMIT = 50000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int TW = $clog2(LIMIT + 1);

  logic [TW-1:0] tcnt_q;
  logic [TW-1:0] tcnt_d;
  logic          tcnt_en;

  assign expired = run && (tcnt_q == TW'(LIMIT - 1));
  assign tcnt_en = run || (tcnt_q != '0);

  always_comb begin
    if (!run)         tcnt_d = '0;
    else if (expired) tcnt_d = tcnt_q;
    else              tcnt_d = tcnt_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       tcnt_q <= '0;
    else if (tcnt_en) tcnt_q <= tcnt_d;
  end

  // R7: the timer cannot expire on the first polling clock
  a_r7_no_instant_expiry: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(run) |-> (!expired || LIMIT == 1));
endmodule

// File: rtl/eeprom_write_poller.sv
module eeprom_write_poller
  import ewp_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SETUP_CYC   = 2,
  parameter int PULSE_CYC   = 4,
  parameter int HOLD_CYC    = 2,
  parameter int READ_CYC    = 3,
  parameter int GAP_CYC     = 4,
  parameter int TIMEOUT_CYC = 50000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [7:0]        req_data,
  input  logic              req_mode_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [7:0]        mem_dout,
  output logic              mem_dout_oe,
  input  logic              mem_poll_msb,
  output logic              mem_ce_n,
  output logic              mem_oe_n,
  output logic              mem_we_n,
  input  logic              rdy_busy_n,
  output logic              done,
  output logic              timeout
);
  localparam int LEN_SUM = SETUP_CYC + PULSE_CYC + HOLD_CYC + READ_CYC + GAP_CYC;
  localparam int CW      = $clog2(LEN_SUM + 1);

  ewp_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q;
  logic [7:0]        data_q;
  logic              mode_q;
  logic              seen_low_q, seen_low_d;
  logic              accept;
  logic              phase_last;
  logic              phase_clear;
  logic [CW-1:0]     phase_len;
  logic              polling;
  logic              expired;
  logic              rdy_s;

  ewp_sync2 u_rdy_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (rdy_busy_n),
    .sync_o  (rdy_s)
  );

  always_comb begin
    unique case (state_q)
      ST_SETUP:      phase_len = CW'(SETUP_CYC);
      ST_PULSE:      phase_len = CW'(PULSE_CYC);
      ST_HOLD:       phase_len = CW'(HOLD_CYC);
      ST_POLL_READ:  phase_len = CW'(READ_CYC);
      ST_POLL_CHECK: phase_len = CW'(GAP_CYC);
      default:       phase_len = CW'(1);
    endcase
  end

  assign phase_clear = (state_d != state_q);

  ewp_phase_counter #(.CW(CW)) u_phase (
    .clk   (clk),
    .rst_n (rst_n),
    .clear (phase_clear),
    .len   (phase_len),
    .last  (phase_last)
  );

  assign polling = (state_q == ST_POLL_CHECK) || (state_q == ST_POLL_READ);

  ewp_timeout_timer #(.LIMIT(TIMEOUT_CYC)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (polling),
    .expired (expired)
  );

  assign req_ready = (state_q == ST_IDLE);
  assign accept    = req_ready && req_valid;

  // next-state logic
  always_comb begin
    state_d    = state_q;
    seen_low_d = seen_low_q;
    unique case (state_q)
      ST_IDLE: begin
        seen_low_d = 1'b0;
        if (req_valid) state_d = ST_SETUP;
      end
      ST_SETUP: if (phase_last) state_d = ST_PULSE;
      ST_PULSE: if (phase_last) state_d = ST_HOLD;
      ST_HOLD: begin
        if (!rdy_s) seen_low_d = 1'b1;
        if (phase_last) state_d = ST_POLL_CHECK;
      end
      ST_POLL_CHECK: begin
        if (mode_q) begin
          if (!rdy_s)                 seen_low_d = 1'b1;
          if (seen_low_q && rdy_s)    state_d = ST_DONE;
          else if (expired)           state_d = ST_TIMEOUT;
        end else begin
          if (expired)                state_d = ST_TIMEOUT;
          else if (phase_last)        state_d = ST_POLL_READ;
        end
      end
      ST_POLL_READ: begin
        if (phase_last && (mem_poll_msb == data_q[7])) state_d = ST_DONE;
        else if (expired)                              state_d = ST_TIMEOUT;
        else if (phase_last)                           state_d = ST_POLL_CHECK;
      end
      ST_DONE:    state_d = ST_IDLE;
      ST_TIMEOUT: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  // state registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      seen_low_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      seen_low_q <= seen_low_d;
    end
  end

  // request capture, enabled only on acceptance
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      data_q <= '0;
      mode_q <= 1'b0;
    end else if (accept) begin
      addr_q <= req_addr;
      data_q <= req_data;
      mode_q <= req_mode_busy;
    end
  end

  // pin decode from the registered state
  always_comb begin
    mem_ce_n    = 1'b1;
    mem_oe_n    = 1'b1;
    mem_we_n    = 1'b1;
    mem_dout_oe = 1'b0;
    unique case (state_q)
      ST_SETUP, ST_HOLD: begin
        mem_ce_n    = 1'b0;
        mem_dout_oe = 1'b1;
      end
      ST_PULSE: begin
        mem_ce_n    = 1'b0;
        mem_we_n    = 1'b0;
        mem_dout_oe = 1'b1;
      end
      ST_POLL_READ: begin
        mem_ce_n = 1'b0;
        mem_oe_n = 1'b0;
      end
      default: ;
    endcase
  end

  assign mem_addr = addr_q;
  assign mem_dout = data_q;
  assign done     = (state_q == ST_DONE);
  assign timeout  = (state_q == ST_TIMEOUT);

  // R3: read strobe is never active during the write strobe
  a_r3_oe_off_while_writing: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_we_n |-> mem_oe_n);
  // R3: the host never drives the bus while the memory drives it
  a_r3_no_contention: assert property (@(posedge clk) disable iff (!rst_n)
    !mem_oe_n |-> !mem_dout_oe);
  // R2: address and data stay put while the chip is selected
  a_r2_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!mem_ce_n && $past(!mem_ce_n)) |-> ($stable(mem_addr) && $stable(mem_dout)));
  // R8: completion pulses last one clock and are mutually exclusive
  a_r8_done_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (!done && req_ready));
  a_r8_timeout_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (!timeout && req_ready));
  a_r8_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(done && timeout));
  // R6: no read strobe in busy-line mode
  a_r6_no_reads_busy_mode: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && !req_ready) |-> mem_oe_n);
  // R9: a request while busy leaves the captured byte untouched
  a_r9_capture_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(req_ready)) |-> ($stable(data_q) && $stable(addr_q)));
endmodule

// File: tb/eeprom_write_poller_tb.sv
module eeprom_write_poller_tb;
  localparam int AW    = 13;
  localparam int SETUP = 2;
  localparam int PULSE = 3;
  localparam int HOLD  = 2;
  localparam int READ  = 2;
  localparam int GAP   = 3;
  localparam int TOUT  = 200;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          req_valid;
  logic          req_ready;
  logic [AW-1:0] req_addr;
  logic [7:0]    req_data;
  logic          req_mode_busy;
  logic [AW-1:0] mem_addr;
  logic [7:0]    mem_dout;
  logic          mem_dout_oe;
  logic          mem_poll_msb;
  logic          mem_ce_n, mem_oe_n, mem_we_n;
  logic          rdy_busy_n;
  logic          done, timeout;

  int checks = 0;
  int fails  = 0;
  int cyc    = 0;

  always #2 clk = ~clk;

  eeprom_write_poller #(
    .ADDR_W(AW), .SETUP_CYC(SETUP), .PULSE_CYC(PULSE), .HOLD_CYC(HOLD),
    .READ_CYC(READ), .GAP_CYC(GAP), .TIMEOUT_CYC(TOUT)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_data(req_data), .req_mode_busy(req_mode_busy),
    .mem_addr(mem_addr), .mem_dout(mem_dout), .mem_dout_oe(mem_dout_oe),
    .mem_poll_msb(mem_poll_msb), .mem_ce_n(mem_ce_n), .mem_oe_n(mem_oe_n),
    .mem_we_n(mem_we_n), .rdy_busy_n(rdy_busy_n), .done(done), .timeout(timeout)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // memory model
  int            busy_cfg = 0;
  int            busy_left = 0;
  logic          prev_we = 1'b1;
  logic          prev_oe = 1'b1;
  logic [AW-1:0] cap_addr = '0;
  logic [7:0]    wr_data = '0;
  int            wcount = 0;
  int            reads = 0;
  int            we_low = 0;
  int            gap_run = 0;
  int            we_rise_cyc = 0;
  int            mon_fail = 0;
  logic [AW-1:0] exp_addr = '0;
  logic [7:0]    exp_data = '0;
  int            ce_run = 0;

  assign rdy_busy_n   = (busy_left == 0);
  assign mem_poll_msb = (busy_left != 0) ? ~wr_data[7] : wr_data[7];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    prev_we <= mem_we_n;
    prev_oe <= mem_oe_n;
    if (!mem_we_n) we_low <= we_low + 1;
    if (!mem_ce_n) ce_run <= ce_run + 1; else ce_run <= 0;
    if (!mem_we_n && prev_we) begin
      cap_addr <= mem_addr;
      if (ce_run != SETUP) begin mon_fail <= mon_fail + 1;
        $display("FAIL R2 setup actual=%0d expected=%0d", ce_run, SETUP); end
    end
    if (mem_we_n && !prev_we) begin
      wr_data <= mem_dout;
      wcount <= wcount + 1;
      busy_left <= busy_cfg;
      we_rise_cyc <= cyc;
      we_low <= 0;
      gap_run <= 0;
      if (we_low != PULSE) begin mon_fail <= mon_fail + 1;
        $display("FAIL R2 pulse width actual=%0d expected=%0d", we_low, PULSE); end
    end else if (busy_left > 0) busy_left <= busy_left - 1;
    if (!mem_we_n && !mem_oe_n) begin mon_fail <= mon_fail + 1;
      $display("FAIL R3 oe during we actual=0 expected=1"); end
    if (!mem_oe_n && mem_dout_oe) begin mon_fail <= mon_fail + 1;
      $display("FAIL R3 bus driven during read actual=1 expected=0"); end
    if (!mem_ce_n && (mem_addr != exp_addr || mem_dout != exp_data)) begin
      mon_fail <= mon_fail + 1;
      $display("FAIL R2/R4 address actual=%0d expected=%0d", mem_addr, exp_addr); end
    if (mem_ce_n && mem_oe_n && mem_we_n) gap_run <= gap_run + 1;
    else if (mem_we_n) gap_run <= 0;
    if (!mem_oe_n && prev_oe) begin
      reads <= reads + 1;
      if (gap_run < GAP) begin mon_fail <= mon_fail + 1;
        $display("FAIL R5 gap actual=%0d expected=%0d", gap_run, GAP); end
    end
  end

  // one operation; expect_to selects expected outcome
  task automatic run_op(input logic [AW-1:0] a, input logic [7:0] d, input bit mode,
                        input int busy, input bit expect_to, input bit poke);
    int w0, r0, waited, mf0;
    bit got_done, got_to;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    busy_cfg = busy;
    w0 = wcount; r0 = reads; mf0 = mon_fail;
    exp_addr = a; exp_data = d;
    req_addr = a; req_data = d; req_mode_busy = mode; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    got_done = 0; got_to = 0; waited = 0;
    while (!got_done && !got_to && waited < 3000) begin
      if (poke && waited == 4) begin
        req_valid = 1'b1; req_data = ~d; req_addr = ~a;
      end else req_valid = 1'b0;
      @(negedge clk);
      waited++;
      got_done = done; got_to = timeout;
    end
    req_valid = 1'b0;
    req_addr = a; req_data = d;
    if (got_done) chk(timeout == 1'b0, "R8 exclusive", timeout, 0);
    chk(got_to == expect_to && got_done == !expect_to, "R7 outcome timeout", got_to, expect_to);
    chk(wcount == w0 + 1, "R9 one write per request", wcount - w0, 1);
    chk(cap_addr == a && wr_data == d, "R2 latched byte", wr_data, d);
    if (mode) chk(reads == r0, "R6 no reads in busy mode", reads - r0, 0);
    else if (!expect_to) chk(busy_left == 0, "R4 done after internal write", busy_left, 0);
    if (expect_to)
      chk((cyc - we_rise_cyc) >= HOLD + TOUT - 1 && (cyc - we_rise_cyc) <= HOLD + TOUT + 2,
          "R7 timeout latency", cyc - we_rise_cyc, HOLD + TOUT);
    chk(mon_fail == mf0, "R2/R3/R5 strobe monitors", mon_fail - mf0, 0);
    @(negedge clk);
    chk(!done && !timeout && req_ready, "R8 single pulse then idle", done, 0);
  endtask

  initial begin
    int w_before;
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_data = '0; req_mode_busy = 1'b0;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(mem_ce_n && mem_oe_n && mem_we_n, "R1 strobes idle", {mem_ce_n, mem_oe_n, mem_we_n}, 7);
    chk(!mem_dout_oe && req_ready && !done && !timeout, "R1 outputs", mem_dout_oe, 0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    // directed corners
    run_op(13'h0000, 8'h00, 1'b0, 0, 1'b0, 1'b0);   // R4 first read already true
    run_op(13'h1FFF, 8'hFF, 1'b0, 25, 1'b0, 1'b0);  // R4 R5 several poll rounds
    run_op(13'h0ABC, 8'h80, 1'b1, 3, 1'b0, 1'b0);   // R6 short busy
    run_op(13'h0123, 8'h5A, 1'b1, 30, 1'b0, 1'b1);  // R9 poke while busy
    w_before = wcount;
    repeat (10) @(negedge clk);
    chk(wcount == w_before && req_ready, "R9 ignored request caused no write", wcount - w_before, 0);
    run_op(13'h0456, 8'h7F, 1'b0, 100000, 1'b1, 1'b0); // R7 data poll timeout
    busy_left = 0;
    run_op(13'h0789, 8'hC3, 1'b1, 100000, 1'b1, 1'b0); // R7 busy timeout
    busy_left = 0;
    repeat (6) @(negedge clk);
    // constrained random
    for (int i = 0; i < 24; i++) begin
      bit m;
      m = $urandom_range(0, 1);
      run_op(AW'($urandom), 8'($urandom), m, m ? $urandom_range(3, 40) : $urandom_range(0, 40),
             1'b0, $urandom_range(0, 3) == 0);
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 150000);
    checks++; fails++;
    $display("FAIL watchdog actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule